// File: doc/BRIEF.md
# Host Bus Command Translator

This block is the slave side of a parallel link to a USB bridge device. The bridge presents a 3-bit control code and a 16-bit data word on every clock. The block turns each code into one of four actions: it latches an address, writes a register, returns a register, or streams a word towards a receive FIFO. A small register bank holds control words for the rest of the chip. It also exposes read-only status words that the host can poll.

Bit 0 of control register 0 chooses the source of display data. After reset it selects the internal pattern generator. When the host sets the bit, the FIFO data that the host supplied is used instead.

During a burst, each data word waits in a one-word holding stage. It is pushed to the FIFO write port only when the next word of the burst arrives. The word still held when the burst ends is therefore never written.

At core level the bidirectional bus is split into an input word, an output word and an output enable. The pad at the chip edge combines them into the shared tri-state bus.

Top module: `host_cmd_xlate`

## Requirements
- R1: After reset, every control register is zero, `srcSelHost` is 0 (pattern generator), `fifoWrEn` is 0 and `busOe` is 0.
- R2: Control code 3'b011 stores the whole `busIn` word as the current address at the clock edge. The address is kept unchanged until the next 3'b011.
- R3: Control code 3'b010 stores `busIn` into control register N at the clock edge, when the current address N is below NUM_CTRL. Register N appears on `ctrlRegs[N*16 +: 16]`.
- R4: While the control code is 3'b001, `busOe` is 1 in the same cycle. `busOut` then carries control register N for address N below NUM_CTRL, or status word K (`statusIn[K*16 +: 16]`) for address NUM_CTRL+K.
- R5: For every control code other than 3'b001, `busOe` is 0.
- R6: A read from an address at or above NUM_CTRL+NUM_STAT returns zero. A write to such an address, or to a status address, changes no control register.
- R7: Under control code 3'b110, each captured word is written to the FIFO port once the next 3'b110 word has been captured. `fifoWrEn` is 1 and `fifoWrData` holds the earlier word in the cycle after that second edge.
- R8: The word captured on the last 3'b110 cycle of a burst is discarded. A burst of N words yields N-1 FIFO writes, and `fifoWrEn` is 0 in the cycle after any edge with a code other than 3'b110.
- R9: `srcSelHost` equals bit 0 of control register 0 (0 = internal pattern generator, 1 = host FIFO data).
- R10: Control codes 3'b111, 3'b000, 3'b100 and 3'b101 are idle. They change no register and the address is kept.

Top module ports, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlCode | input | 3 | Transaction code from the bridge |
| busIn | input | 16 | Data bus value as seen at the pad |
| busOut | output | 16 | Read data to drive onto the bus |
| busOe | output | 1 | Pad output enable, high only during a read |
| statusIn | input | NUM_STAT*16 | Read-only status words, word K at bits K*16 up |
| ctrlRegs | output | NUM_CTRL*16 | Control register contents, register N at bits N*16 up |
| srcSelHost | output | 1 | Display data source: 0 pattern generator, 1 host FIFO |
| fifoWrEn | output | 1 | Receive FIFO write strobe |
| fifoWrData | output | 16 | Receive FIFO write data |

## Verification
The properties assume that `ctlCode` and `busIn` are always known values that change only between clock edges, with never an X or Z on the input side of the split bus. They also assume that the FIFO port accepts a write in every cycle, since the block has no back-pressure. The bench keeps within this by driving every input on the falling edge from tasks and covering all eight code values. It also varies `statusIn` only between transactions, so a read sees a settled status word.

// File: rtl/hcx_pkg.sv
package hcx_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE  = 3'b111,
    CMD_ADDR  = 3'b011,
    CMD_WRITE = 3'b010,
    CMD_READ  = 3'b001,
    CMD_BURST = 3'b110
  } hcxCmd_e;

  typedef struct packed {
    logic latchAddr;
    logic wrReg;
    logic rdDrive;
    logic burstWord;
  } hcxStrobe_t;

endpackage

// File: rtl/hcx_ctrl.sv
module hcx_ctrl
  import hcx_pkg::*;
(
  input  logic [2:0]  ctlCode,
  output hcxStrobe_t  strobe
);

  // One strobe per recognised code; the remaining codes leave all strobes low.
  always_comb begin
    strobe = '0;
    case (ctlCode)
      CMD_ADDR:  strobe.latchAddr = 1'b1;
      CMD_WRITE: strobe.wrReg     = 1'b1;
      CMD_READ:  strobe.rdDrive   = 1'b1;
      CMD_BURST: strobe.burstWord = 1'b1;
      default:   strobe = '0;
    endcase
  end

endmodule

// File: rtl/hcx_dpath.sv
module hcx_dpath
  import hcx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_CTRL = 4,
  parameter int NUM_STAT = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  hcxStrobe_t                   strobe,
  input  logic [DATA_W-1:0]            busIn,
  input  logic [NUM_STAT*DATA_W-1:0]   statusIn,
  output logic [DATA_W-1:0]            busOut,
  output logic                         busOe,
  output logic [NUM_CTRL*DATA_W-1:0]   ctrlRegs,
  output logic                         fifoWrEn,
  output logic [DATA_W-1:0]            fifoWrData
);

  logic [DATA_W-1:0] addrQ;
  logic [DATA_W-1:0] ctrlQ [NUM_CTRL];
  logic [DATA_W-1:0] holdQ;
  logic              holdValidQ;
  logic [DATA_W-1:0] rdData;

  // Address register: the full word is kept so large values stay unmapped.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 addrQ <= '0;
    else if (strobe.latchAddr) addrQ <= busIn;
  end

  // Writable control bank, one register per generate slice.
  for (genvar g = 0; g < NUM_CTRL; g++) begin : gCtrl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        ctrlQ[g] <= '0;
      else if (strobe.wrReg && (addrQ == DATA_W'(g)))
        ctrlQ[g] <= busIn;
    end
    assign ctrlRegs[g*DATA_W +: DATA_W] = ctrlQ[g];
  end

  // Read mux: the control bank first, then status, and zero for anything else.
  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (addrQ == DATA_W'(i)) rdData = ctrlQ[i];
    for (int k = 0; k < NUM_STAT; k++)
      if (addrQ == DATA_W'(NUM_CTRL + k)) rdData = statusIn[k*DATA_W +: DATA_W];
  end

  assign busOut = rdData;
  assign busOe  = strobe.rdDrive;

  // Burst path: hold one word and push it when its successor arrives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdQ      <= '0;
      holdValidQ <= 1'b0;
      fifoWrEn   <= 1'b0;
      fifoWrData <= '0;
    end else if (strobe.burstWord) begin
      holdQ      <= busIn;
      holdValidQ <= 1'b1;
      fifoWrEn   <= holdValidQ;
      if (holdValidQ) fifoWrData <= holdQ;
    end else begin
      holdValidQ <= 1'b0;
      fifoWrEn   <= 1'b0;
    end
  end

endmodule

// File: rtl/host_cmd_xlate.sv
module host_cmd_xlate
  import hcx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_CTRL = 4,
  parameter int NUM_STAT = 2,
  parameter int SRC_BIT  = 0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [2:0]                   ctlCode,
  input  logic [DATA_W-1:0]            busIn,
  output logic [DATA_W-1:0]            busOut,
  output logic                         busOe,
  input  logic [NUM_STAT*DATA_W-1:0]   statusIn,
  output logic [NUM_CTRL*DATA_W-1:0]   ctrlRegs,
  output logic                         srcSelHost,
  output logic                         fifoWrEn,
  output logic [DATA_W-1:0]            fifoWrData
);

  hcxStrobe_t strobe;

  hcx_ctrl i_ctrl (
    .ctlCode (ctlCode),
    .strobe  (strobe)
  );

  hcx_dpath #(
    .DATA_W   (DATA_W),
    .NUM_CTRL (NUM_CTRL),
    .NUM_STAT (NUM_STAT)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busIn      (busIn),
    .statusIn   (statusIn),
    .busOut     (busOut),
    .busOe      (busOe),
    .ctrlRegs   (ctrlRegs),
    .fifoWrEn   (fifoWrEn),
    .fifoWrData (fifoWrData)
  );

  assign srcSelHost = ctrlRegs[SRC_BIT];

endmodule

// File: rtl/hcx_checker.sv
module hcx_checker
  import hcx_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int NUM_CTRL = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [2:0]                 ctlCode,
  input logic [DATA_W-1:0]          busIn,
  input logic                       busOe,
  input logic [NUM_CTRL*DATA_W-1:0] ctrlRegs,
  input logic                       srcSelHost,
  input logic                       fifoWrEn,
  input logic [DATA_W-1:0]          fifoWrData
);

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (ctlCode == CMD_READ)); // R5

  AST_FIFO_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> ($past(ctlCode) == CMD_BURST && $past(ctlCode, 2) == CMD_BURST)); // R7

  AST_FIFO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    fifoWrEn |-> (fifoWrData == $past(busIn, 2))); // R7

  AST_DROP_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (ctlCode != CMD_BURST) |=> !fifoWrEn); // R8

  AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctlCode != CMD_WRITE) |=> $stable(srcSelHost)); // R9

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (ctlCode != CMD_WRITE) |=> $stable(ctrlRegs)); // R10

endmodule

bind host_cmd_xlate hcx_checker #(
  .DATA_W   (DATA_W),
  .NUM_CTRL (NUM_CTRL)
) i_hcx_checker (
  .clk        (clk),
  .rstN       (rstN),
  .ctlCode    (ctlCode),
  .busIn      (busIn),
  .busOe      (busOe),
  .ctrlRegs   (ctrlRegs),
  .srcSelHost (srcSelHost),
  .fifoWrEn   (fifoWrEn),
  .fifoWrData (fifoWrData)
);

// File: tb/test_host_cmd_xlate.sv
module test_host_cmd_xlate;

  localparam int DW = 16;
  localparam int NC = 4;
  localparam int NS = 2;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [2:0]     ctlCode = 3'b111;
  logic [DW-1:0]  busIn = '0;
  logic [DW-1:0]  busOut;
  logic           busOe;
  logic [NS*DW-1:0] statusIn = '0;
  logic [NC*DW-1:0] ctrlRegs;
  logic           srcSelHost;
  logic           fifoWrEn;
  logic [DW-1:0]  fifoWrData;

  int vecs = 0;
  int errs = 0;
  logic [DW-1:0] mCtrl [NC];
  logic [DW-1:0] mAddr = '0;

  always #5 clk = ~clk;

  host_cmd_xlate #(.DATA_W(DW), .NUM_CTRL(NC), .NUM_STAT(NS)) i_host_cmd_xlate (
    .clk(clk), .rstN(rstN), .ctlCode(ctlCode), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .statusIn(statusIn), .ctrlRegs(ctrlRegs), .srcSelHost(srcSelHost),
    .fifoWrEn(fifoWrEn), .fifoWrData(fifoWrData)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] expRead(input logic [DW-1:0] a);
    if (a < NC) return mCtrl[a];
    if (a < NC + NS) return statusIn[(a - NC)*DW +: DW];
    return '0;
  endfunction

  function automatic logic [NC*DW-1:0] expBank();
    logic [NC*DW-1:0] v;
    for (int i = 0; i < NC; i++) v[i*DW +: DW] = mCtrl[i];
    return v;
  endfunction

  // Drive at the falling edge, let one rising edge pass, return at the next falling edge.
  task automatic step(input logic [2:0] code, input logic [DW-1:0] d);
    ctlCode = code;
    busIn   = d;
    #1;
    if (code == 3'b001) begin
      chk(busOe == 1'b1, "R4 oe", 64'(busOe), 64'd1);
      chk(busOut == expRead(mAddr), "R4/R6 read", 64'(busOut), 64'(expRead(mAddr)));
    end else begin
      chk(busOe == 1'b0, "R5 oe", 64'(busOe), 64'd0);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkBank(input string req);
    chk(ctrlRegs == expBank(), req, 64'(ctrlRegs), 64'(expBank()));
    chk(srcSelHost == mCtrl[0][0], "R9 srcSelHost", 64'(srcSelHost), 64'(mCtrl[0][0]));
  endtask

  task automatic doLatch(input logic [DW-1:0] a);
    step(3'b011, a);
    mAddr = a;
  endtask

  task automatic doWrite(input logic [DW-1:0] v);
    step(3'b010, v);
    if (mAddr < NC) mCtrl[mAddr] = v;
    checkBank("R3/R6 write");
  endtask

  task automatic doIdle(input logic [2:0] code);
    step(code, DW'($urandom));
    chk(fifoWrEn == 1'b0, "R8/R10 no write", 64'(fifoWrEn), 64'd0);
    checkBank("R10 idle");
  endtask

  task automatic doBurst(input int n);
    logic [DW-1:0] prev = '0;
    for (int i = 0; i < n; i++) begin
      logic [DW-1:0] w = DW'($urandom);
      step(3'b110, w);
      if (i == 0) begin
        chk(fifoWrEn == 1'b0, "R8 no leftover", 64'(fifoWrEn), 64'd0);
      end else begin
        chk(fifoWrEn == 1'b1, "R7 write strobe", 64'(fifoWrEn), 64'd1);
        chk(fifoWrData == prev, "R7 write data", 64'(fifoWrData), 64'(prev));
      end
      prev = w;
    end
    doIdle(3'b111);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240));
    for (int i = 0; i < NC; i++) mCtrl[i] = '0;
    statusIn = {16'hA5C3, 16'h3C5A};
    repeat (3) @(negedge clk);
    // R1: reset state
    checkBank("R1 reset bank");
    chk(fifoWrEn == 1'b0, "R1 fifoWrEn", 64'(fifoWrEn), 64'd0);
    chk(busOe == 1'b0, "R1 busOe", 64'(busOe), 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2/R9: set source select, address persists across later operations
    doLatch(16'd0);
    doWrite(16'h0001);
    chk(srcSelHost == 1'b1, "R9 host select", 64'(srcSelHost), 64'd1);
    doIdle(3'b000);
    doIdle(3'b100);
    doIdle(3'b101);
    step(3'b001, '0);               // R2: address 0 still latched
    doWrite(16'hBEE0);
    chk(srcSelHost == 1'b0, "R9 pattern select", 64'(srcSelHost), 64'd0);

    // R4/R6: status reads, writes to status and unmapped addresses are ignored
    doLatch(16'd4);  step(3'b001, '0);
    doWrite(16'hFFFF); step(3'b001, '0);
    doLatch(16'd5);  step(3'b001, '0);
    doLatch(16'd6);  doWrite(16'h1234); step(3'b001, '0);
    doLatch(16'h8003); doWrite(16'h5555); step(3'b001, '0);
    doLatch(16'd3);  doWrite(16'h7E7E); step(3'b001, '0);

    // R7/R8: single-word burst yields no write, back-to-back bursts
    doBurst(1);
    doBurst(2);
    doBurst(5);

    // Random mix
    for (int n = 0; n < 400; n++) begin
      int op = int'($urandom % 7);
      case (op)
        0: doLatch(($urandom % 4 == 0) ? DW'($urandom) : DW'($urandom % 8));
        1: doWrite(DW'($urandom));
        2: step(3'b001, DW'($urandom));
        3: doBurst(1 + int'($urandom % 6));
        4: begin
             logic [2:0] ic [4] = '{3'b111, 3'b000, 3'b100, 3'b101};
             doIdle(ic[$urandom % 4]);
           end
        5: statusIn = {DW'($urandom), DW'($urandom)};
        default: begin doLatch(DW'($urandom % 6)); step(3'b001, '0); end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule